// File: doc/BRIEF.md
# Dual-copy control register bank

This block holds a small bank of control registers for a configurable device. Each of the shadowed registers (slots 1 to 4 by default) keeps two copies of every bit. A retained copy models nonvolatile storage and survives a power-on reset. A working copy drives the device's function outputs. A configuration register (slot 0) and an auxiliary register (the slot after the last shadowed one, slot 5 by default) are plain single-copy registers.

Software reaches the bank through one request stream and one read-response stream, each with a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Only reads produce a response. The response stays on `rsp_data` with `rsp_valid` high until `rsp_ready` is seen high. While a response is stalled, `req_ready` stays low, so no second response can be lost. After every power-on reset the bank spends one cycle copying the retained cells into the working cells, and `req_ready` is low during that cycle.

A mode bit in the configuration register selects how shadowed writes behave. In write-through mode a write updates both copies. In working-only mode it updates only the working copy, and a later write to slot 0 or the auxiliary slot restores the working copies from the retained ones. An active-low write-protect pin blocks every write.

Top module: `shadow_ctl_bank`

## Requirements
- R1: While `rst_n` is low and afterwards, the configuration and auxiliary registers read 0 and `rsp_valid` is low. In the first cycle after `rst_n` rises, `req_ready` is low. In the next cycle it is high.
- R2: After a power-on reset, `work_o` equals the retained contents of every shadowed register, including values that were programmed before the reset.
- R3: When bit MODE_BIT (bit 0 by default) of the configuration register is 1, a write to shadowed slot k updates both its working copy and its retained copy.
- R4: When that mode bit is 0, a write to shadowed slot k updates only its working copy. The retained copy keeps its old value.
- R5: With `wp_n` high and the mode bit 0, a write to slot 0 or to the auxiliary slot reloads every working copy from its retained copy. The mode bit that is tested is the value held before the current write.
- R6: While `wp_n` is low, writes to any slot are ignored, including slots 0 and 5, and no reload occurs. Reads are still served.
- R7: A read of slot 0 or slot 5 returns the stored value. A read of a shadowed slot returns its retained copy, never its working copy. Reads of unmapped slots (6 and 7) return 0, and writes to those slots change nothing.
- R8: `work_o` packs shadowed slot k into bits [8k-1 : 8k-8] (slot 1 in bits 7:0). It shows a new value in the cycle after the accepting edge of a write or reload.
- R9: A read response is held, with `rsp_data` stable, while `rsp_ready` is low. During that stall `req_ready` is low. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wp_n | input | 1 | Write protect, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (3) | Register slot |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | DATA_W (8) | Read data |
| work_o | output | NUM_SHADOW*DATA_W (32) | Working copies of the shadowed slots |

## Verification
The bench builds the bank with its defaults: 8-bit data, a 3-bit address, four shadowed slots and the mode bit at position 0. The 3-bit address puts the unmapped slots 6 and 7 within reach, so ignored writes and zero reads can be checked there. Four slots let the bench hold one slot divergent while others stay aligned. This shows that a reload restores every slot and that a blocked write disturbs none.

// File: rtl/shadow_ctl_pkg.sv
package shadow_ctl_pkg;
  // slot index of the configuration register holding the mode bit
  localparam int unsigned CFG_SLOT = 0;

  // the auxiliary single-copy register sits just after the shadowed slots
  function automatic int unsigned aux_slot(input int unsigned n_shadow);
    return n_shadow + 1;
  endfunction
endpackage

// File: rtl/shadow_ctl_cell.sv
module shadow_ctl_cell #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_work,
  input  logic              wr_keep,
  input  logic              reload,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] work_q,
  output logic [DATA_W-1:0] keep_q
);
  // retained copy: not cleared by power-on reset
  always_ff @(posedge clk) begin
    if (wr_keep) keep_q <= wdata;
  end

  // working copy: cleared by reset, reloaded from the retained copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       work_q <= '0;
    else if (reload)  work_q <= keep_q;
    else if (wr_work) work_q <= wdata;
  end
endmodule

// File: rtl/shadow_ctl_decode.sv
module shadow_ctl_decode #(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned NUM_SHADOW = 4
) (
  input  logic                  fire,
  input  logic                  is_wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wp_n,
  input  logic                  mode_q,
  output logic                  cfg_we,
  output logic                  aux_we,
  output logic [NUM_SHADOW-1:0] work_we,
  output logic [NUM_SHADOW-1:0] keep_we,
  output logic                  reload
);
  import shadow_ctl_pkg::*;
  localparam int unsigned AUX_SLOT = aux_slot(NUM_SHADOW);

  logic wr_ok;
  assign wr_ok  = fire && is_wr && wp_n;
  assign cfg_we = wr_ok && (addr == ADDR_W'(CFG_SLOT));
  assign aux_we = wr_ok && (addr == ADDR_W'(AUX_SLOT));
  // the mode tested here is the value held before this write lands
  assign reload = (cfg_we || aux_we) && !mode_q;

  for (genvar k = 0; k < NUM_SHADOW; k++) begin : g_slot
    assign work_we[k] = wr_ok && (addr == ADDR_W'(k + 1));
    assign keep_we[k] = work_we[k] && mode_q;
  end
endmodule

// File: rtl/shadow_ctl_rsp.sv
module shadow_ctl_rsp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              stalled
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ld_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign stalled = rsp_valid && !rsp_ready;
endmodule

// File: rtl/shadow_ctl_bank.sv
module shadow_ctl_bank #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned NUM_SHADOW = 4,
  parameter int unsigned MODE_BIT   = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wp_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [DATA_W-1:0]            rsp_data,
  output logic [NUM_SHADOW*DATA_W-1:0] work_o
);
  import shadow_ctl_pkg::*;
  localparam int unsigned AUX_SLOT = aux_slot(NUM_SHADOW);
  localparam int unsigned FLAT_W   = NUM_SHADOW * DATA_W;

  logic                  recall_q;
  logic [DATA_W-1:0]     cfg_q, aux_q, rd_data;
  logic [FLAT_W-1:0]     nv_flat;
  logic                  fire, stalled;
  logic                  cfg_we, aux_we, dec_reload;
  logic [NUM_SHADOW-1:0] work_we, keep_we;

  // one reload cycle follows every power-on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recall_q <= 1'b1;
    else        recall_q <= 1'b0;
  end

  assign req_ready = !recall_q && !stalled;
  assign fire      = req_valid && req_ready;

  shadow_ctl_decode #(.ADDR_W(ADDR_W), .NUM_SHADOW(NUM_SHADOW)) dec_i (
    .fire    (fire),
    .is_wr   (req_write),
    .addr    (req_addr),
    .wp_n    (wp_n),
    .mode_q  (cfg_q[MODE_BIT]),
    .cfg_we  (cfg_we),
    .aux_we  (aux_we),
    .work_we (work_we),
    .keep_we (keep_we),
    .reload  (dec_reload)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      aux_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= req_wdata;
      if (aux_we) aux_q <= req_wdata;
    end
  end

  for (genvar k = 0; k < NUM_SHADOW; k++) begin : g_cell
    shadow_ctl_cell #(.DATA_W(DATA_W)) cell_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_work (work_we[k]),
      .wr_keep (keep_we[k]),
      .reload  (recall_q || dec_reload),
      .wdata   (req_wdata),
      .work_q  (work_o[k*DATA_W +: DATA_W]),
      .keep_q  (nv_flat[k*DATA_W +: DATA_W])
    );
  end

  // shadowed slots always read back their retained copy
  always_comb begin
    rd_data = '0;
    if (req_addr == ADDR_W'(CFG_SLOT)) rd_data = cfg_q;
    if (req_addr == ADDR_W'(AUX_SLOT)) rd_data = aux_q;
    for (int k = 0; k < int'(NUM_SHADOW); k++) begin
      if (req_addr == ADDR_W'(k + 1)) rd_data = nv_flat[k*DATA_W +: DATA_W];
    end
  end

  shadow_ctl_rsp #(.DATA_W(DATA_W)) rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire && !req_write),
    .ld_data   (rd_data),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .stalled   (stalled)
  );
endmodule

// File: rtl/shadow_ctl_chk.sv
module shadow_ctl_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned NUM_SHADOW = 4,
  parameter int unsigned MODE_BIT   = 0
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wp_n,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         req_write,
  input logic [ADDR_W-1:0]            req_addr,
  input logic                         rsp_valid,
  input logic                         rsp_ready,
  input logic [DATA_W-1:0]            rsp_data,
  input logic [NUM_SHADOW*DATA_W-1:0] work_o,
  input logic [NUM_SHADOW*DATA_W-1:0] nv_flat,
  input logic [DATA_W-1:0]            cfg_q,
  input logic                         recall_q
);
  localparam int unsigned AUX_A = NUM_SHADOW + 1;

  logic wr_fire, hit_ctl, hit_shadow;
  assign wr_fire    = req_valid && req_ready && req_write;
  assign hit_ctl    = (req_addr == ADDR_W'(0)) || (req_addr == ADDR_W'(AUX_A));
  assign hit_shadow = (req_addr != ADDR_W'(0)) && (req_addr <= ADDR_W'(NUM_SHADOW));

  // R1 and R9: no request is taken during the reload cycle
  a_r1_ready_low_in_recall: assert property (@(posedge clk) disable iff (!rst_n)
    recall_q |-> !req_ready);

  // R2: power-up reload leaves working copies equal to retained ones
  a_r2_powerup_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recall_q) |-> (work_o == nv_flat));

  // R4: working-only mode leaves retained copies alone
  a_r4_keep_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wp_n && hit_shadow && !cfg_q[MODE_BIT]) |=> $stable(nv_flat));

  // R5: write to slot 0 or aux in working-only mode reloads
  a_r5_reload_on_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wp_n && hit_ctl && !cfg_q[MODE_BIT]) |=> (work_o == nv_flat));

  // R6: protected writes change nothing
  a_r6_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wp_n) |=> ($stable(work_o) && $stable(nv_flat) && $stable(cfg_q)));

  // R9: stalled response is held
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: a stalled response blocks new requests
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind shadow_ctl_bank shadow_ctl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SHADOW(NUM_SHADOW), .MODE_BIT(MODE_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .work_o(work_o), .nv_flat(nv_flat),
  .cfg_q(cfg_q), .recall_q(recall_q)
);

// File: tb/shadow_ctl_bank_tb_top.sv
`timescale 1ns/1ps
module shadow_ctl_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_n = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [31:0] work_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] nv_m [1:4];
  logic [7:0] vol_m [1:4];
  logic [7:0] cfg_m = '0;
  logic [7:0] aux_m = '0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  shadow_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .work_o(work_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] work_exp();
    return {vol_m[4], vol_m[3], vol_m[2], vol_m[1]};
  endfunction

  function automatic logic [7:0] read_exp(input logic [2:0] a);
    if (a == 3'd0) return cfg_m;
    if (a == 3'd5) return aux_m;
    if (a >= 3'd1 && a <= 3'd4) return nv_m[a];
    return 8'h00;
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    if (!wp_n) return;
    if (a == 3'd0 || a == 3'd5) begin
      if (!cfg_m[0]) for (int k = 1; k <= 4; k++) vol_m[k] = nv_m[k];
      if (a == 3'd0) cfg_m = d; else aux_m = d;
    end else if (a >= 3'd1 && a <= 3'd4) begin
      vol_m[a] = d;
      if (cfg_m[0]) nv_m[a] = d;
    end
  endtask

  // driver: returns at the negedge after the accepting edge
  task automatic send(input logic w, input logic [2:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (!w) begin exp_q.push_back(read_exp(a)); tag_q.push_back(tag); end
    else model_write(a, d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops at each response handshake
  always @(posedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R9 unexpected response", {24'h0, rsp_data}, 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), {24'h0, rsp_data}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic power_on();
    @(negedge clk); rst_n = 1'b0;
    cfg_m = '0; aux_m = '0;
    for (int k = 1; k <= 4; k++) vol_m[k] = nv_m[k];
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    #1 chk("R1 ready low in reload cycle", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    chk("R1 ready high after reload", {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 1; k <= 4; k++) begin nv_m[k] = '0; vol_m[k] = '0; end
    power_on();
    send(1'b0, 3'd0, 8'h00, "R1 cfg reads 0");
    send(1'b0, 3'd5, 8'h00, "R1 aux reads 0");

    // R3: write-through programming
    send(1'b1, 3'd0, 8'h01, "R3 set mode");
    send(1'b1, 3'd1, 8'hA1, "R3"); chk("R8 slot1 next cycle", work_o[7:0], 32'hA1);
    send(1'b1, 3'd2, 8'hB2, "R3");
    send(1'b1, 3'd3, 8'hC3, "R3");
    send(1'b1, 3'd4, 8'hD4, "R3");
    chk("R3 work after write-through", work_o, work_exp());
    send(1'b0, 3'd2, 8'h00, "R3 slot2 read retained");
    send(1'b0, 3'd4, 8'h00, "R3 slot4 read retained");

    // R4: working-only
    send(1'b1, 3'd0, 8'h00, "R4 clear mode");
    chk("R5 no reload when old mode 1", work_o, work_exp());
    send(1'b1, 3'd2, 8'h5A, "R4");
    chk("R4 working copy updated", work_o, work_exp());
    chk("R8 slot2 packing", {24'h0, work_o[15:8]}, 32'h5A);
    send(1'b0, 3'd2, 8'h00, "R7 read returns retained not working");

    // R5: aux write reloads
    send(1'b1, 3'd5, 8'h33, "R5");
    chk("R5 aux write reloads", work_o, work_exp());
    send(1'b1, 3'd3, 8'h77, "R4");
    chk("R4 slot3 working only", work_o, work_exp());
    send(1'b1, 3'd0, 8'h01, "R5");
    chk("R5 cfg write reloads using old mode", work_o, work_exp());
    send(1'b0, 3'd0, 8'h00, "R7 cfg readback");
    send(1'b0, 3'd5, 8'h00, "R7 aux readback");

    // R6: write protect
    send(1'b1, 3'd0, 8'h00, "R6 prep");
    send(1'b1, 3'd4, 8'h4E, "R6 prep");
    @(negedge clk); wp_n = 1'b0;
    send(1'b1, 3'd0, 8'hFF, "R6");
    send(1'b1, 3'd5, 8'hEE, "R6");
    send(1'b1, 3'd1, 8'h99, "R6");
    chk("R6 no change and no reload under protect", work_o, work_exp());
    send(1'b0, 3'd0, 8'h00, "R6 cfg unchanged");
    send(1'b0, 3'd5, 8'h00, "R6 aux unchanged");
    send(1'b0, 3'd1, 8'h00, "R6 slot1 retained unchanged");
    @(negedge clk); wp_n = 1'b1;

    // R7: unmapped slots
    send(1'b1, 3'd6, 8'h66, "R7");
    chk("R7 unmapped write no effect", work_o, work_exp());
    send(1'b0, 3'd6, 8'h00, "R7 unmapped read 6");
    send(1'b0, 3'd7, 8'h00, "R7 unmapped read 7");

    // R9: back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    send(1'b0, 3'd3, 8'h00, "R9 held response");
    chk("R9 valid held", {31'h0, rsp_valid}, 32'h1);
    chk("R9 ready low during stall", {31'h0, req_ready}, 32'h0);
    @(negedge clk); @(negedge clk);
    chk("R9 data stable", {24'h0, rsp_data}, {24'h0, exp_q[0]});
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", {31'h0, rsp_valid}, 32'h0);

    // R2: power cycle with a divergent working copy
    send(1'b1, 3'd1, 8'h12, "R2 prep");
    power_on();
    chk("R2 reload after power-on", work_o, work_exp());
    send(1'b0, 3'd0, 8'h00, "R1 cfg reads 0 after power cycle");
    send(1'b0, 3'd1, 8'h00, "R2 retained survives reset");
    repeat (3) @(negedge clk);
    chk("R9 all responses seen", exp_q.size(), 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule